// File: doc/BRIEF.md
# Prescaled Timer Counter with Control

This block is a free-running 16-bit up counter. It advances once for every 64 bus clocks, and a 6-bit prescaler sets that rate. The prescaler's wrap pulse serves two purposes. It is the counter's count enable, and it also leaves the block as a divide-by-64 tick for a companion pulse accumulator.

A control register holds the run enable and the halt-during-wait bit. It also stores three bits that other parts of the chip use: freeze, fast flag clear and precision prescaler select.

Software reaches the block through a small byte-addressed port.
- Offset 0x04 is the counter high byte and offset 0x05 is the low byte.
- A word access at 0x04 covers both halves in one cycle.
- Offset 0x06 is the control register.
- Reads are combinational.
- Writes take effect on the next rising clock edge.
- Counter writes take effect only while the special-mode input is high.

Top module: `ptim_top`

## Requirements
- R1: After reset the counter reads 0x0000, the control register reads 0x00 and the tick output is low.
- R2: The control register at offset 0x06 can be read and written at any time. Bit 7 is enable, bit 6 is halt-in-wait, bit 5 is freeze, bit 4 is fast flag clear and bit 3 is precision select. Bits 2..0 ignore writes and read as zero.
- R3: While the timer is active, the tick output is a one-cycle pulse every 64 bus clocks. The first pulse comes in the 64th cycle after the timer becomes active.
- R4: The counter rises by one on the clock edge that ends a tick cycle, and it wraps from 0xFFFF to 0x0000.
- R5: With enable at 0, the counter and the prescaler hold their values and the tick stays low.
- R6: With halt-in-wait at 1 and the wait input high, the timer halts as in R5. With halt-in-wait at 0, the timer keeps running while the wait input is high.
- R7: When the special-mode input is low, writes to offsets 0x04 and 0x05 leave the counter unchanged.
- R8: When the special-mode input is high, counter writes take effect as follows:
  - a word write at 0x04 loads wdata[15:0];
  - a byte write at 0x04 loads wdata[7:0] into the high byte;
  - a byte write at 0x05 loads wdata[7:0] into the low byte.
- R9: A counter write does not touch the prescaler. The next tick arrives at the same phase it would have had without the write.
- R10: When a counter write and a tick fall in the same cycle, the written value is loaded and that increment is lost.
- R11: A word read at 0x04 returns {high, low} of the counter in the same cycle. Byte reads return the addressed byte in rdata[7:0] with rdata[15:8] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_mode | input | 1 | Chip is in wait mode |
| special_mode | input | 1 | Chip is in a special mode; allows counter writes |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_word | input | 1 | Access is 16 bits wide |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| count_o | output | 16 | Current counter value |
| tick64_o | output | 1 | Divide-by-64 pulse |

## Verification
Two functions can land on the same clock edge: a special-mode counter write and a prescaler tick. The bench finds a tick by sampling the tick output. In that same cycle it issues a word write, then checks that the counter holds exactly the written value rather than that value plus one. The bench also checks that the following tick arrives exactly 64 cycles after the previous one, which shows that the write left the prescaler alone.

// File: rtl/ptim_pkg.sv
package ptim_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 6;
  localparam int ADDR_W = 4;
  localparam int LANES  = CNT_W / 8;

  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h6;

  typedef struct packed {
    logic run_en;
    logic halt_wait;
    logic freeze;
    logic fast_clr;
    logic prec_sel;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cur);
    return cur + 1'b1;
  endfunction

  function automatic logic pre_at_wrap(input logic [PRE_W-1:0] pre);
    return pre == {PRE_W{1'b1}};
  endfunction

  function automatic logic [7:0] ctrl_pack(input ctrl_t c);
    return {c.run_en, c.halt_wait, c.freeze, c.fast_clr, c.prec_sel, 3'b000};
  endfunction
endpackage

// File: rtl/ptim_ctrl.sv
module ptim_ctrl
  import ptim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [7:0] wr_byte,
  input  logic       wait_mode,
  output ctrl_t      ctrl_q,
  output logic       active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wr_byte[7:3];
    end
  end

  assign active = ctrl_q.run_en & ~(ctrl_q.halt_wait & wait_mode);

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_pack(ctrl_q) == {$past(wr_byte[7:3]), 3'b000}); // R2
endmodule

// File: rtl/ptim_prescaler.sv
module ptim_prescaler
  import ptim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (active) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign tick = active & pre_at_wrap(pre_q);

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(pre_q)); // R5
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> active); // R6
endmodule

// File: rtl/ptim_counter.sv
module ptim_counter
  import ptim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [LANES-1:0] wr_lane,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_q
);
  logic             any_wr;
  logic [CNT_W-1:0] base;

  assign any_wr = |wr_lane;
  assign base   = (tick && !any_wr) ? cnt_step(count_q) : count_q;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        count_q[b*8 +: 8] <= '0;
      end else if (wr_lane[b]) begin
        count_q[b*8 +: 8] <= wr_data[b*8 +: 8];
      end else begin
        count_q[b*8 +: 8] <= base[b*8 +: 8];
      end
    end
  end

  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_wr) |=> count_q == $past(count_q) + 1'b1); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !any_wr) |=> $stable(count_q)); // R5
  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (&wr_lane) |=> count_q == $past(wr_data)); // R10
endmodule

// File: rtl/ptim_top.sv
module ptim_top
  import ptim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_mode,
  input  logic              special_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [CNT_W-1:0]  count_o,
  output logic              tick64_o
);
  ctrl_t            ctrl_q;
  logic             active;
  logic             tick;
  logic             wr_ctrl;
  logic             hit_hi;
  logic             hit_lo;
  logic [LANES-1:0] wr_lane;
  logic [CNT_W-1:0] wr_data;
  logic [CNT_W-1:0] count_q;

  assign hit_hi  = bus_addr == OFS_CNT_HI;
  assign hit_lo  = bus_addr == OFS_CNT_LO;
  assign wr_ctrl = bus_wr && !bus_word && bus_addr == OFS_CTRL;

  always_comb begin
    wr_lane = '0;
    wr_data = '0;
    if (bus_wr && special_mode) begin
      if (hit_hi && bus_word) begin
        wr_lane = '1;
        wr_data = bus_wdata;
      end else if (hit_hi) begin
        wr_lane[1]      = 1'b1;
        wr_data[15:8]   = bus_wdata[7:0];
      end else if (hit_lo && !bus_word) begin
        wr_lane[0]      = 1'b1;
        wr_data[7:0]    = bus_wdata[7:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_hi && bus_word)          bus_rdata = count_q;
    else if (hit_hi)                 bus_rdata[7:0] = count_q[15:8];
    else if (hit_lo)                 bus_rdata[7:0] = count_q[7:0];
    else if (bus_addr == OFS_CTRL)   bus_rdata[7:0] = ctrl_pack(ctrl_q);
  end

  ptim_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_byte(bus_wdata[7:0]),
    .wait_mode(wait_mode), .ctrl_q(ctrl_q), .active(active)
  );

  ptim_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(tick)
  );

  ptim_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lane(wr_lane),
    .wr_data(wr_data), .count_q(count_q)
  );

  assign count_o  = count_q;
  assign tick64_o = tick;

  AST_NORMAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && !tick) |=> $stable(count_q)); // R7
  AST_WAIT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.halt_wait && wait_mode) |-> !tick); // R6
endmodule

// File: tb/ptim_top_tb_top.sv
module ptim_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wait_mode = 0;
  logic        special_mode = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic        bus_word = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [15:0] count_o;
  logic        tick64_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptim_top dut_i (
    .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode), .special_mode(special_mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .count_o(count_o), .tick64_o(tick64_o)
  );

  // control table: {write byte, expected read byte}
  localparam logic [15:0] CTRL_VEC [6] = '{16'hFF_F8, 16'h07_00, 16'hA8_A8,
                                           16'h50_50, 16'h18_18, 16'h00_00};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_wr = 0; wait_mode = 0; special_mode = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  // drive at negedge, commit at posedge, return at next negedge
  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic w);
    bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_word = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic w, output logic [15:0] d);
    bus_addr = a; bus_word = w;
    #1 d = bus_rdata;
    bus_word = 0;
  endtask

  // advance until tick seen at a negedge; returns cycles waited
  task automatic wait_tick(input int lim, output int n);
    n = 0;
    while (!tick64_o && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    logic [15:0] d;
    int n;
    int seen;
    logic [15:0] c0;
    do_reset();
    // R1
    rd(4'h4, 1, d); chk("R1 count", d, 16'h0000);
    rd(4'h6, 0, d); chk("R1 ctrl", d, 16'h0000);
    chk("R1 tick", {15'b0, tick64_o}, 16'h0);

    // R2 table
    for (int i = 0; i < 6; i++) begin
      wr(4'h6, {8'h00, CTRL_VEC[i][15:8]}, 0);
      rd(4'h6, 0, d);
      chk("R2 ctrl", d, {8'h00, CTRL_VEC[i][7:0]});
    end

    // R3/R4 first tick after enable
    do_reset();
    wr(4'h6, 16'h0080, 0);
    wait_tick(200, n);
    chk("R3 first tick", n[15:0], 16'd63);
    chk("R4 before inc", count_o, 16'h0000);
    @(negedge clk);
    chk("R3 one cycle", {15'b0, tick64_o}, 16'h0);
    chk("R4 inc", count_o, 16'h0001);
    wait_tick(200, n);
    chk("R3 period", n[15:0], 16'd63);
    @(negedge clk);
    chk("R4 second", count_o, 16'h0002);

    // R11 reads
    rd(4'h4, 0, d); chk("R11 hi", d, 16'h0000);
    rd(4'h5, 0, d); chk("R11 lo", d, 16'h0002);

    // R7 write ignored in normal mode (just after a tick, no tick soon)
    wr(4'h4, 16'h5555, 1);
    wr(4'h5, 16'h0077, 0);
    chk("R7 ignored", count_o, 16'h0002);

    // R8 special writes, R9 phase kept: 2 cycles used since tick edge
    special_mode = 1;
    wr(4'h4, 16'h00AB, 0);
    chk("R8 hi byte", count_o, 16'hAB02);
    wr(4'h5, 16'h00CD, 0);
    chk("R8 lo byte", count_o, 16'hABCD);
    rd(4'h4, 1, d); chk("R11 word", d, 16'hABCD);
    wait_tick(200, n);
    chk("R9 phase", n[15:0], 16'd59);

    // R10 write coincides with tick
    wr(4'h4, 16'h1234, 1);
    chk("R10 write wins", count_o, 16'h1234);

    // R4 wrap
    wr(4'h4, 16'hFFFF, 1);
    special_mode = 0;
    wait_tick(200, n);
    @(negedge clk);
    chk("R4 wrap", count_o, 16'h0000);

    // R5 disable
    wr(4'h6, 16'h0000, 0);
    c0 = count_o; seen = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (tick64_o) seen++;
    end
    chk("R5 no tick", seen[15:0], 16'd0);
    chk("R5 hold", count_o, c0);

    // R6 halt in wait
    wait_mode = 1;
    wr(4'h6, 16'h00C0, 0);
    c0 = count_o; seen = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (tick64_o) seen++;
    end
    chk("R6 halted tick", seen[15:0], 16'd0);
    chk("R6 halted cnt", count_o, c0);
    wr(4'h6, 16'h0080, 0);
    wait_tick(200, n);
    chk("R6 runs in wait", {15'b0, tick64_o}, 16'h1);
    @(negedge clk);
    chk("R6 count in wait", count_o, c0 + 16'h1);
    wait_mode = 0;

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule